// File: doc/BRIEF.md
# SMI feature negotiation controller

This block settles, once per reset, which optional SMI features a guest may use. The host's offer is a 64-bit elaboration parameter. Software writes a 64-bit request as two 32-bit words, lower word first in the address map. It then writes the confirm register. In the next clock the block checks the request against the offer and against the dependency rules between feature bits. If the request is legal, the block latches it as the negotiated set and locks. After that point, no further confirm has any effect until reset.

The negotiated broadcast bit decides how APM command strobes become SMI pulses. A strobe can raise SMI on the CPU that issued the command, or on every CPU. It raises nothing when the APM SMI enable bit is clear. Two command codes are kept apart for ACPI mode switching: these only pulse an enable or disable output and never raise SMI.

Top module: `smi_feat_ctrl`

## Requirements
- R1: After `rst_n` rises, the block stays in reset for two more rising clock edges. In reset, every readable register reads 0 and all pulse outputs are 0. Asserting `rst_n` low clears the state at once.
- R2: Register address 0 holds request bits 31:0 and address 1 holds bits 63:32. Both read back as written. Address 3 bit 0 is the APM SMI enable. Address 4 reads negotiated bits 31:0, address 5 reads bits 63:32, and unused addresses read 0.
- R3: A write to address 2 (confirm) validates the request. If the request has any bit outside `HOST_FEATURES`, validation fails and address 2 keeps reading 0.
- R4: Feature bit 0 is broadcast, bit 1 is CPU hot-add and bit 2 is CPU hot-remove. A request with bit 1 or bit 2 set and bit 0 clear fails validation.
- R5: A request with bit 2 set and bit 1 clear fails validation.
- R6: On a legal request, the confirm write latches the request as the negotiated set. Address 2 reads 1 from the cycle after the write.
- R7: Once address 2 reads 1, further confirm writes and request changes leave the negotiated set and the flag unchanged until reset.
- R8: An APM strobe with command 8'hE1 gives a one-cycle pulse on `acpi_on_pulse`. Command 8'h1E gives a one-cycle pulse on `acpi_off_pulse`. Neither raises SMI, whatever the enable bit.
- R9: Any other APM command raises no SMI while the enable bit is 0.
- R10: With the enable bit set and broadcast negotiated, any other command pulses every bit of `smi_out` for one cycle, in the cycle after the strobe.
- R11: With the enable bit set and broadcast not negotiated, only bit `apm_cpu` of `smi_out` pulses, for one cycle.
- R12: A reset after a successful negotiation clears the request, the flag, the negotiated set and the enable bit. A fresh negotiation can then succeed.

A `HOST_FEATURES` value that offers hot-remove without hot-add is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| apm_stb | input | 1 | APM command strobe, one cycle |
| apm_cmd | input | 8 | APM command byte |
| apm_cpu | input | CPU_W | Index of the CPU issuing the command |
| smi_out | output | NUM_CPUS | SMI pulse, one bit per CPU |
| acpi_on_pulse | output | 1 | ACPI enable command seen |
| acpi_off_pulse | output | 1 | ACPI disable command seen |

## Verification
The properties assume that `apm_cpu` always names an existing CPU whenever `apm_stb` is high. They also assume that register writes and APM strobes are never issued while the block is still in reset. The stimulus drives only CPU indices below `NUM_CPUS`, and it waits out the release delay before the first access. A behavioural model runs alongside the design and is compared every cycle. It follows the same request sequence through legal, illegal and post-lock confirms, with the enable bit both set and clear.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int FEAT_W   = 64;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int HALVES   = FEAT_W / WORD_W;

  // Feature bit positions; the dependency rules hinge on them.
  localparam int BIT_BCAST  = 0;
  localparam int BIT_HOTADD = 1;
  localparam int BIT_HOTDEL = 2;

  typedef logic [FEAT_W-1:0] feat_t;

  typedef enum logic [ADDR_W-1:0] {
    RA_REQ_LO  = 3'd0,
    RA_REQ_HI  = 3'd1,
    RA_CONFIRM = 3'd2,
    RA_SMI_CTL = 3'd3,
    RA_NEG_LO  = 3'd4,
    RA_NEG_HI  = 3'd5
  } reg_addr_e;

  // True when a request may be accepted against a host offer.
  function automatic logic feat_set_legal(feat_t req, feat_t host);
    logic outside;
    logic needs_bcast;
    logic needs_add;
    outside     = |(req & ~host);
    needs_bcast = (req[BIT_HOTADD] | req[BIT_HOTDEL]) & ~req[BIT_BCAST];
    needs_add   = req[BIT_HOTDEL] & ~req[BIT_HOTADD];
    return !(outside | needs_bcast | needs_add);
  endfunction
endpackage

// File: rtl/smi_rst_sync.sv
module smi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smi_req_regs.sv
module smi_req_regs
  import smi_neg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output feat_t             req,
  output logic              apmc_en
);
  // Request words, little-endian: half h sits at address RA_REQ_LO + h.
  for (genvar h = 0; h < HALVES; h++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic              word_we;

    always_comb begin
      word_we = wr_en && (wr_addr == ADDR_W'(int'(RA_REQ_LO) + h));
      word_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_we) begin
        word_q <= word_d;
      end
    end

    assign req[h*WORD_W +: WORD_W] = word_q;
  end

  logic ctl_q;
  logic ctl_d;
  logic ctl_we;

  always_comb begin
    ctl_we = wr_en && (wr_addr == RA_SMI_CTL);
    ctl_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  assign apmc_en = ctl_q;
endmodule

// File: rtl/smi_validator.sv
module smi_validator
  import smi_neg_pkg::*;
#(
  parameter feat_t HOST_FEATURES = 64'h7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  confirm,
  input  feat_t req,
  output logic  ok,
  output feat_t neg
);
  logic  ok_q;
  logic  accept;
  feat_t neg_q;

  // One-shot: once locked, confirm is ignored.
  always_comb begin
    accept = confirm && !ok_q && feat_set_legal(req, HOST_FEATURES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      neg_q <= '0;
    end else if (accept) begin
      ok_q  <= 1'b1;
      neg_q <= req;
    end
  end

  assign ok  = ok_q;
  assign neg = neg_q;
endmodule

// File: rtl/smi_dispatch.sv
module smi_dispatch #(
  parameter int         NUM_CPUS = 4,
  parameter int         CPU_W    = 2,
  parameter logic [7:0] ON_CMD   = 8'hE1,
  parameter logic [7:0] OFF_CMD  = 8'h1E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                apm_stb,
  input  logic [7:0]          apm_cmd,
  input  logic [CPU_W-1:0]    apm_cpu,
  input  logic                apmc_en,
  input  logic                bcast,
  output logic [NUM_CPUS-1:0] smi_out,
  output logic                acpi_on,
  output logic                acpi_off
);
  logic                is_on;
  logic                is_off;
  logic                raise;
  logic [NUM_CPUS-1:0] smi_d;
  logic [NUM_CPUS-1:0] smi_q;
  logic                on_q;
  logic                off_q;

  always_comb begin
    is_on  = apm_stb && (apm_cmd == ON_CMD);
    is_off = apm_stb && (apm_cmd == OFF_CMD) && !is_on;
    raise  = apm_stb && !is_on && !is_off && apmc_en;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign smi_d[c] = raise && (bcast || (apm_cpu == CPU_W'(c)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= '0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      smi_q <= smi_d;
      on_q  <= is_on;
      off_q <= is_off;
    end
  end

  assign smi_out  = smi_q;
  assign acpi_on  = on_q;
  assign acpi_off = off_q;
endmodule

// File: rtl/smi_feat_ctrl.sv
module smi_feat_ctrl
  import smi_neg_pkg::*;
#(
  parameter int         NUM_CPUS      = 4,
  parameter feat_t      HOST_FEATURES = 64'h7,
  parameter logic [7:0] ACPI_ON_CMD   = 8'hE1,
  parameter logic [7:0] ACPI_OFF_CMD  = 8'h1E,
  localparam int        CPU_W         = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                apm_stb,
  input  logic [7:0]          apm_cmd,
  input  logic [CPU_W-1:0]    apm_cpu,
  output logic [NUM_CPUS-1:0] smi_out,
  output logic                acpi_on_pulse,
  output logic                acpi_off_pulse
);
  // Offering hot-remove without hot-add can never negotiate legally.
  if (HOST_FEATURES[BIT_HOTDEL] && !HOST_FEATURES[BIT_HOTADD]) begin : g_bad_host
    $error("smi_feat_ctrl: HOST_FEATURES offers hot-remove without hot-add");
  end

  logic  rst_sync_n;
  feat_t feat_req;
  feat_t feat_neg;
  logic  feat_ok;
  logic  apmc_en;
  logic  confirm;

  smi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  smi_req_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .req     (feat_req),
    .apmc_en (apmc_en)
  );

  assign confirm = reg_wr && (reg_addr == RA_CONFIRM);

  smi_validator #(.HOST_FEATURES(HOST_FEATURES)) u_val (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .confirm (confirm),
    .req     (feat_req),
    .ok      (feat_ok),
    .neg     (feat_neg)
  );

  smi_dispatch #(
    .NUM_CPUS (NUM_CPUS),
    .CPU_W    (CPU_W),
    .ON_CMD   (ACPI_ON_CMD),
    .OFF_CMD  (ACPI_OFF_CMD)
  ) u_disp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .apm_stb  (apm_stb),
    .apm_cmd  (apm_cmd),
    .apm_cpu  (apm_cpu),
    .apmc_en  (apmc_en),
    .bcast    (feat_neg[BIT_BCAST]),
    .smi_out  (smi_out),
    .acpi_on  (acpi_on_pulse),
    .acpi_off (acpi_off_pulse)
  );

  always_comb begin
    unique case (reg_addr)
      RA_REQ_LO:  reg_rdata = feat_req[WORD_W-1:0];
      RA_REQ_HI:  reg_rdata = feat_req[FEAT_W-1:WORD_W];
      RA_CONFIRM: reg_rdata = {{(WORD_W-1){1'b0}}, feat_ok};
      RA_SMI_CTL: reg_rdata = {{(WORD_W-1){1'b0}}, apmc_en};
      RA_NEG_LO:  reg_rdata = feat_neg[WORD_W-1:0];
      RA_NEG_HI:  reg_rdata = feat_neg[FEAT_W-1:WORD_W];
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smi_feat_ctrl_chk.sv
module smi_feat_ctrl_chk
  import smi_neg_pkg::*;
#(
  parameter int    NUM_CPUS      = 4,
  parameter feat_t HOST_FEATURES = 64'h7
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                apm_stb,
  input logic                apmc_en,
  input logic                feat_ok,
  input feat_t               feat_neg,
  input logic [NUM_CPUS-1:0] smi_out,
  input logic                acpi_on_pulse,
  input logic                acpi_off_pulse
);
  // R6
  ok_rise_after_confirm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(feat_ok) |-> $past(reg_wr && (reg_addr == 3'd2)));

  // R7
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(feat_ok) |-> (feat_ok && $stable(feat_neg)));

  // R3
  neg_within_host_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    feat_ok |-> ((feat_neg & ~HOST_FEATURES) == '0));

  // R8
  acpi_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acpi_on_pulse || acpi_off_pulse) |-> (smi_out == '0));

  // R8
  acpi_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({acpi_on_pulse, acpi_off_pulse}));

  // R9
  smi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smi_out != '0) |-> $past(apm_stb && apmc_en));

  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((smi_out != '0) && !$past(feat_neg[BIT_BCAST])) |-> ($countones(smi_out) == 1));

  // R10
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((smi_out != '0) && $past(feat_neg[BIT_BCAST])) |-> (&smi_out));
endmodule

bind smi_feat_ctrl smi_feat_ctrl_chk #(
  .NUM_CPUS      (NUM_CPUS),
  .HOST_FEATURES (HOST_FEATURES)
) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .apm_stb        (apm_stb),
  .apmc_en        (apmc_en),
  .feat_ok        (feat_ok),
  .feat_neg       (feat_neg),
  .smi_out        (smi_out),
  .acpi_on_pulse  (acpi_on_pulse),
  .acpi_off_pulse (acpi_off_pulse)
);

// File: tb/tb_smi_feat_ctrl.sv
module tb_smi_feat_ctrl;
  localparam int          NCPU = 4;
  localparam logic [63:0] HOST = 64'h7;
  localparam logic [7:0]  CMD_ON  = 8'hE1;
  localparam logic [7:0]  CMD_OFF = 8'h1E;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        apm_stb;
  logic [7:0]  apm_cmd;
  logic [1:0]  apm_cpu;
  logic [3:0]  smi_out;
  logic        acpi_on_pulse;
  logic        acpi_off_pulse;

  int    checks;
  int    failures;
  bit    done;
  bit    cmp_en;
  string cur_req;

  smi_feat_ctrl #(.NUM_CPUS(NCPU), .HOST_FEATURES(HOST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apm_stb(apm_stb),
    .apm_cmd(apm_cmd), .apm_cpu(apm_cpu), .smi_out(smi_out),
    .acpi_on_pulse(acpi_on_pulse), .acpi_off_pulse(acpi_off_pulse)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [63:0] m_req, m_neg;
  logic        m_ok, m_ctl, m_on, m_off;
  logic [3:0]  m_smi;
  int          m_wait;

  function automatic bit legal(logic [63:0] r);
    if ((r & ~HOST) != 64'd0) return 0;
    if ((r[1] || r[2]) && !r[0]) return 0;
    if (r[2] && !r[1]) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_req[31:0];
      3'd1: return m_req[63:32];
      3'd2: return {31'd0, m_ok};
      3'd3: return {31'd0, m_ctl};
      3'd4: return m_neg[31:0];
      3'd5: return m_neg[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_clear();
    m_req = '0; m_neg = '0; m_ok = 0; m_ctl = 0;
    m_smi = '0; m_on = 0; m_off = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0;
      m_clear();
    end else if (m_wait < 2) begin
      m_wait++;
      m_clear();
    end else begin
      logic [3:0] s;
      logic       on, off;
      s = '0; on = 0; off = 0;
      if (apm_stb) begin
        if (apm_cmd == CMD_ON) on = 1;
        else if (apm_cmd == CMD_OFF) off = 1;
        else if (m_ctl) s = m_neg[0] ? 4'hF : (4'b0001 << apm_cpu);
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_req[31:0]  = reg_wdata;
          3'd1: m_req[63:32] = reg_wdata;
          3'd2: if (!m_ok && legal(m_req)) begin m_neg = m_req; m_ok = 1; end
          3'd3: m_ctl = reg_wdata[0];
          default: ;
        endcase
      end
      m_smi = s; m_on = on; m_off = off;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      if (smi_out !== m_smi || acpi_on_pulse !== m_on || acpi_off_pulse !== m_off ||
          reg_rdata !== m_read(reg_addr)) begin
        failures++;
        $display("FAIL %s model: smi=%h on=%b off=%b rd=%h expected smi=%h on=%b off=%b rd=%h",
                 cur_req, smi_out, acpi_on_pulse, acpi_off_pulse, reg_rdata,
                 m_smi, m_on, m_off, m_read(reg_addr));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd_expect(logic [2:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  // Issues a strobe; returns just after the edge that registers the response.
  task automatic apm(logic [7:0] c, logic [1:0] cpu);
    apm_stb = 1; apm_cmd = c; apm_cpu = cpu;
    step();
    apm_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
    step();
    step();
    step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0; cmp_en = 0;
    cur_req = "R1";
    rst_n = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    apm_stb = 0; apm_cmd = 0; apm_cpu = 0;
    #2 rst_n = 0;
    #1 cmp_en = 1;
    step(); step();
    rst_n = 1;
    step(); step(); step();

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_expect(3'(a), 32'd0, "R1 reset read");
    check("R1 smi idle", {28'd0, smi_out}, 32'd0);

    // R9: enable clear, ordinary command
    cur_req = "R9";
    apm(8'h42, 2'd2);
    check("R9 no smi while disabled", {28'd0, smi_out}, 32'd0);

    // R8: ACPI codes with enable set
    cur_req = "R8";
    wr(3'd3, 32'd1);
    rd_expect(3'd3, 32'd1, "R2 enable readback");
    apm(CMD_ON, 2'd1);
    check("R8 on pulse", {30'd0, acpi_on_pulse, acpi_off_pulse}, 32'd2);
    check("R8 no smi on enable code", {28'd0, smi_out}, 32'd0);
    apm(CMD_OFF, 2'd1);
    check("R8 off pulse", {30'd0, acpi_on_pulse, acpi_off_pulse}, 32'd1);
    check("R8 no smi on disable code", {28'd0, smi_out}, 32'd0);
    step();
    check("R8 pulse one cycle", {30'd0, acpi_on_pulse, acpi_off_pulse}, 32'd0);

    // R11: no broadcast negotiated
    cur_req = "R11";
    apm(8'h42, 2'd2);
    check("R11 single target cpu2", {28'd0, smi_out}, 32'h4);
    apm(8'h00, 2'd0);
    check("R11 single target cpu0", {28'd0, smi_out}, 32'h1);
    step();
    check("R11 pulse one cycle", {28'd0, smi_out}, 32'd0);

    // R2: request halves
    cur_req = "R2";
    wr(3'd0, 32'h0000_0001);
    wr(3'd1, 32'h0000_0100);
    rd_expect(3'd0, 32'h0000_0001, "R2 low word");
    rd_expect(3'd1, 32'h0000_0100, "R2 high word");
    wr(3'd4, 32'hFFFF_FFFF);
    rd_expect(3'd4, 32'd0, "R2 negotiated word not writable");

    // R3: bit outside host offer
    cur_req = "R3";
    wr(3'd2, 32'd1);
    rd_expect(3'd2, 32'd0, "R3 ok stays 0");
    rd_expect(3'd5, 32'd0, "R3 nothing latched");

    // R4: hot-plug without broadcast
    cur_req = "R4";
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'd1);
    rd_expect(3'd2, 32'd0, "R4 hotadd without bcast");
    wr(3'd0, 32'h6);
    wr(3'd2, 32'd1);
    rd_expect(3'd2, 32'd0, "R4 both hot bits without bcast");

    // R5: hot-remove without hot-add
    cur_req = "R5";
    wr(3'd0, 32'h5);
    wr(3'd2, 32'd1);
    rd_expect(3'd2, 32'd0, "R5 hotdel without hotadd");

    // R6: legal request
    cur_req = "R6";
    wr(3'd0, 32'h1);
    reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'd1;
    step();
    reg_wr = 0;
    rd_expect(3'd2, 32'd1, "R6 ok next cycle");
    rd_expect(3'd4, 32'h1, "R6 negotiated low");
    rd_expect(3'd5, 32'h0, "R6 negotiated high");

    // R10: broadcast
    cur_req = "R10";
    apm(8'h42, 2'd1);
    check("R10 all cpus", {28'd0, smi_out}, 32'hF);
    step();
    check("R10 pulse one cycle", {28'd0, smi_out}, 32'd0);

    // R7: locked
    cur_req = "R7";
    wr(3'd0, 32'h7);
    wr(3'd2, 32'd1);
    rd_expect(3'd4, 32'h1, "R7 negotiated unchanged");
    rd_expect(3'd2, 32'd1, "R7 ok stays set");
    wr(3'd1, 32'h100);
    wr(3'd2, 32'd1);
    rd_expect(3'd5, 32'h0, "R7 high unchanged");

    // R12: reset clears, renegotiation works
    cur_req = "R12";
    rst_n = 0;
    reg_addr = 3'd2;
    #1;
    check("R12 async clear ok", reg_rdata, 32'd0);
    step(); step();
    rst_n = 1;
    step(); step(); step();
    rd_expect(3'd0, 32'd0, "R12 request cleared");
    rd_expect(3'd3, 32'd0, "R12 enable cleared");
    rd_expect(3'd4, 32'd0, "R12 negotiated cleared");
    apm(8'h42, 2'd3);
    check("R12 no smi after reset", {28'd0, smi_out}, 32'd0);
    wr(3'd0, 32'h7);
    wr(3'd2, 32'd1);
    rd_expect(3'd2, 32'd1, "R12 renegotiate ok");
    rd_expect(3'd4, 32'h7, "R12 full set latched");
    wr(3'd3, 32'd1);
    apm(8'h42, 2'd3);
    check("R10 broadcast after renegotiation", {28'd0, smi_out}, 32'hF);
    step(); step();

    done = 1;
    summary();
    $finish;
  end
endmodule